// File: doc/BRIEF.md
# ADC Output Test Pattern Generator

This block sits between the converter core and the output formatter of an 11-bit pipelined ADC. In normal operation it forwards each conversion word unchanged. When a 4-bit pattern code selects a test pattern, it replaces the conversion word with a known word instead. The downstream formatter and drivers then carry a predictable stream, so the capture logic on the far side of the link can be checked without an analog input.

The patterns are:
- constant words at midscale, positive full scale and negative full scale;
- a checkerboard;
- a word that alternates between all ones and all zeros;
- two pseudo-random streams, one from a 9-stage generator and one from a 23-stage generator.

Each pseudo-random generator has its own hold input, which keeps it at its seed while the input is set. Every word is registered once, so each output word appears one sample clock after the inputs that chose it. All pattern words are offset binary. Output coding is applied later in the formatter.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: Code 0000 passes `conv_data` to `pat_data` one clock later, and `pat_active` is 0.
- R2: Codes 0001, 0010 and 0011 give the constant words 0x400, 0x7FF and 0x000 one clock later.
- R3: Code 0100 gives a checkerboard. A phase bit toggles on every clock after reset, starting at 0. Phase 0 gives 0x555 and phase 1 gives 0x2AA.
- R4: Code 0111 gives 0x7FF in phase 0 and 0x000 in phase 1, using the same phase bit as R3.
- R5: Code 0110 gives the 9-stage sequence for x^9+x^5+1. For each bit, the feedback is stage 9 XOR stage 5, and it is shifted in at bit 0. Each word is the next 11 feedback bits, with the first bit at the MSB. The state advances 11 steps on every clock.
- R6: Code 0101 gives the 23-stage sequence for x^23+x^18+1, formed in the same way from stage 23 XOR stage 18.
- R7: While `pn9_hold` or `pn23_hold` is 1, that generator reloads all ones on each clock. Each hold affects only its own generator.
- R8: Codes 1000 through 1111 behave exactly like code 0000.
- R9: `pat_active` is 1 exactly when the output word of the same cycle came from a pattern code (0001 to 0111).
- R10: A synchronous active-low reset clears `pat_data`, `pat_active` and the phase bit, and seeds both generators with all ones. The generators run on every clock whatever the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tp_mode | input | 4 | Pattern code |
| pn9_hold | input | 1 | Holds the 9-stage generator at its seed |
| pn23_hold | input | 1 | Holds the 23-stage generator at its seed |
| conv_data | input | 11 | Conversion word from the core |
| pat_data | output | 11 | Registered output word, offset binary |
| pat_active | output | 1 | The output word is a test pattern |

## Verification
The properties assume that reset is held for at least one clock. Each history-based check waits until enough clocks have passed since reset. The alternation and hold properties also require the pattern code, and for the hold property the hold bit, to stay constant over the cycles they look back across.

The stimulus changes inputs only between clock edges. It holds each code for runs of several words, so these assumptions are met whenever a property is checked. Arbitrary codes and hold settings are still applied in other cycles, where those properties are not checked.

// File: rtl/tpg_pkg.sv
// Shared constants for the test pattern generator: the pattern code
// values. Assumes a 4-bit code field.
package tpg_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] TP_OFF     = 4'b0000;
    localparam logic [MODE_W-1:0] TP_MID     = 4'b0001;
    localparam logic [MODE_W-1:0] TP_POS_FS  = 4'b0010;
    localparam logic [MODE_W-1:0] TP_NEG_FS  = 4'b0011;
    localparam logic [MODE_W-1:0] TP_CHECKER = 4'b0100;
    localparam logic [MODE_W-1:0] TP_PN_LONG = 4'b0101;
    localparam logic [MODE_W-1:0] TP_PN_SHRT = 4'b0110;
    localparam logic [MODE_W-1:0] TP_ONEZERO = 4'b0111;
endpackage

// File: rtl/tpg_prbs.sv
// Fibonacci LFSR that makes one WORD_W-bit word per clock.
// Feedback = stage LEN xor stage TAP, shifted in at bit 0. The word is
// the next WORD_W feedback bits, first bit at the MSB. The generator runs
// on every clock. Reset or hold reloads the all-ones seed.
module tpg_prbs #(
    parameter int LEN    = 9,
    parameter int TAP    = 5,
    parameter int WORD_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    output logic [WORD_W-1:0] word_o
);
    localparam logic [LEN-1:0] SEED = '1;

    logic [LEN-1:0] state_q;
    logic [LEN-1:0] state_nxt;

    // Unroll WORD_W shift steps to form the word and the next state.
    always_comb begin
        logic [LEN-1:0] s;
        logic           fb;
        s      = state_q;
        word_o = '0;
        for (int i = 0; i < WORD_W; i++) begin
            fb = s[LEN-1] ^ s[TAP-1];
            s  = {s[LEN-2:0], fb};
            word_o[WORD_W-1-i] = fb;
        end
        state_nxt = s;
    end

    // State register: seed on reset or hold, otherwise advance one word.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) state_q <= SEED;
        else                state_q <= state_nxt;
    end
endmodule

// File: rtl/tpg_select.sv
// Combinational selector that picks the pattern word for a code.
// Assumes offset-binary words. Codes outside 0001..0111 select the
// conversion word and clear the active flag.
module tpg_select
    import tpg_pkg::*;
#(
    parameter int DATA_W = 11
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              phase,
    input  logic [DATA_W-1:0] conv_word,
    input  logic [DATA_W-1:0] pn_short_word,
    input  logic [DATA_W-1:0] pn_long_word,
    output logic [DATA_W-1:0] word_o,
    output logic              active_o
);
    localparam logic [DATA_W-1:0] MID_WORD = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ONES     = '1;
    localparam logic [DATA_W-1:0] ZEROS    = '0;

    logic [DATA_W-1:0] chk_even;

    // Checkerboard word with ones on even bit positions.
    generate
        for (genvar g = 0; g < DATA_W; g++) begin : g_chk
            assign chk_even[g] = (g % 2 == 0);
        end
    endgenerate

    // Code decode: choose the word and the active flag.
    always_comb begin
        active_o = 1'b1;
        case (mode)
            TP_MID:     word_o = MID_WORD;
            TP_POS_FS:  word_o = ONES;
            TP_NEG_FS:  word_o = ZEROS;
            TP_CHECKER: word_o = phase ? ~chk_even : chk_even;
            TP_ONEZERO: word_o = phase ? ZEROS : ONES;
            TP_PN_LONG: word_o = pn_long_word;
            TP_PN_SHRT: word_o = pn_short_word;
            default: begin
                word_o   = conv_word;
                active_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/adc_test_pattern_gen.sv
// Top of the test pattern generator. Holds two free-running PN
// generators and a phase bit. Registers the selected word with one clock
// of latency. Assumes a synchronous active-low reset.
module adc_test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int DATA_W     = 11,
    parameter int PN_S_LEN   = 9,
    parameter int PN_S_TAP   = 5,
    parameter int PN_L_LEN   = 23,
    parameter int PN_L_TAP   = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        tp_mode,
    input  logic              pn9_hold,
    input  logic              pn23_hold,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] pat_data,
    output logic              pat_active
);
    logic              phase_q;
    logic [DATA_W-1:0] pn_s_word;
    logic [DATA_W-1:0] pn_l_word;
    logic [DATA_W-1:0] sel_word;
    logic              sel_active;

    tpg_prbs #(.LEN(PN_S_LEN), .TAP(PN_S_TAP), .WORD_W(DATA_W)) pn_short_i (
        .clk(clk), .rst_n(rst_n), .hold(pn9_hold), .word_o(pn_s_word)
    );

    tpg_prbs #(.LEN(PN_L_LEN), .TAP(PN_L_TAP), .WORD_W(DATA_W)) pn_long_i (
        .clk(clk), .rst_n(rst_n), .hold(pn23_hold), .word_o(pn_l_word)
    );

    tpg_select #(.DATA_W(DATA_W)) sel_i (
        .mode(tp_mode), .phase(phase_q), .conv_word(conv_data),
        .pn_short_word(pn_s_word), .pn_long_word(pn_l_word),
        .word_o(sel_word), .active_o(sel_active)
    );

    // Phase bit for the alternating patterns, toggles every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    // Output register: one clock from code and data to the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_data   <= '0;
            pat_active <= 1'b0;
        end else begin
            pat_data   <= sel_word;
            pat_active <= sel_active;
        end
    end
endmodule

// File: rtl/tpg_checker.sv
// Properties of the pattern generator, attached to the top by bind.
// Counts clocks since reset so that no check looks back past reset.
module tpg_checker #(
    parameter int DATA_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        tp_mode,
    input logic              pn9_hold,
    input logic [DATA_W-1:0] conv_data,
    input logic [DATA_W-1:0] pat_data,
    input logic              pat_active
);
    logic [1:0] since_rst;

    // Saturating count of clocks since reset was released.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(tp_mode) == 4'b0000)
        |-> (pat_data == $past(conv_data) && !pat_active)); // R1

    AST_FIXED_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(tp_mode) == 4'b0001)
        |-> (pat_data == {1'b1, {(DATA_W-1){1'b0}}})); // R2

    AST_CHECKER_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(tp_mode) == 4'b0100 && $past(tp_mode, 2) == 4'b0100)
        |-> (pat_data != $past(pat_data) && $countones(pat_data) == DATA_W / 2 + (DATA_W % 2))
            || (pat_data != $past(pat_data) && $countones(pat_data) == DATA_W / 2)); // R3

    AST_ONEZERO_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(tp_mode) == 4'b0111 && $past(tp_mode, 2) == 4'b0111)
        |-> (pat_data == ~$past(pat_data) && ($countones(pat_data) == 0 || &pat_data))); // R4

    AST_PN9_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(tp_mode) == 4'b0110 && $past(tp_mode, 2) == 4'b0110
         && $past(pn9_hold) && $past(pn9_hold, 2) && $past(pn9_hold, 3))
        |-> $stable(pat_data)); // R7

    AST_UNUSED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(tp_mode[3]))
        |-> (pat_data == $past(conv_data) && !pat_active)); // R8

    AST_ACTIVE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1)
        |-> (pat_active == ($past(tp_mode) >= 4'b0001 && $past(tp_mode) <= 4'b0111))); // R9
endmodule

bind adc_test_pattern_gen tpg_checker #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tp_mode(tp_mode), .pn9_hold(pn9_hold),
    .conv_data(conv_data), .pat_data(pat_data), .pat_active(pat_active)
);

// File: tb/adc_test_pattern_gen_tb.sv
// Self-checking bench: a stimulus table walked by one loop, then
// directed tests for reset, hold and unused codes.
module adc_test_pattern_gen_tb_top;
    localparam int W = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   tp_mode = 4'd0;
    logic         pn9_hold = 1'b0;
    logic         pn23_hold = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic [W-1:0] pat_data;
    logic         pat_active;

    int checks = 0;
    int bad = 0;

    // Reference state, kept from the requirements only.
    logic [22:0]  m_pn23;
    logic [8:0]   m_pn9;
    logic         m_phase;

    always #2 clk = ~clk;

    adc_test_pattern_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tp_mode(tp_mode), .pn9_hold(pn9_hold),
        .pn23_hold(pn23_hold), .conv_data(conv_data),
        .pat_data(pat_data), .pat_active(pat_active)
    );

    // Stimulus rows: {mode, pn23_hold, pn9_hold, conv_data}
    typedef struct packed {
        logic [3:0]   mode;
        logic         h23;
        logic         h9;
        logic [W-1:0] data;
    } row_t;

    localparam int NROWS = 20;
    localparam row_t ROWS [NROWS] = '{
        '{4'h0, 1'b0, 1'b0, 11'h123}, '{4'h0, 1'b0, 1'b0, 11'h7A5},
        '{4'h1, 1'b0, 1'b0, 11'h0F0}, '{4'h2, 1'b0, 1'b0, 11'h0F0},
        '{4'h3, 1'b0, 1'b0, 11'h0F0}, '{4'h4, 1'b0, 1'b0, 11'h001},
        '{4'h4, 1'b0, 1'b0, 11'h002}, '{4'h4, 1'b0, 1'b0, 11'h003},
        '{4'h7, 1'b0, 1'b0, 11'h004}, '{4'h7, 1'b0, 1'b0, 11'h005},
        '{4'h6, 1'b0, 1'b0, 11'h006}, '{4'h6, 1'b0, 1'b0, 11'h007},
        '{4'h6, 1'b0, 1'b0, 11'h008}, '{4'h5, 1'b0, 1'b0, 11'h009},
        '{4'h5, 1'b0, 1'b0, 11'h00A}, '{4'h5, 1'b0, 1'b0, 11'h00B},
        '{4'h8, 1'b0, 1'b0, 11'h3C3}, '{4'hC, 1'b0, 1'b0, 11'h555},
        '{4'hF, 1'b0, 1'b0, 11'h2AA}, '{4'h0, 1'b0, 1'b0, 11'h7FF}
    };

    function automatic logic [W-1:0] pn_word(input logic [22:0] s0, input int len, input int tap);
        logic [22:0] s = s0;
        logic fb;
        for (int i = 0; i < W; i++) begin
            fb = s[len-1] ^ s[tap-1];
            s = (s << 1) | 23'(fb);
            pn_word[W-1-i] = fb;
        end
    endfunction

    function automatic logic [22:0] pn_next(input logic [22:0] s0, input int len, input int tap);
        logic [22:0] s = s0;
        logic fb;
        for (int i = 0; i < W; i++) begin
            fb = s[len-1] ^ s[tap-1];
            s = (s << 1) | 23'(fb);
        end
        pn_next = s & ((23'd1 << len) - 23'd1);
    endfunction

    function automatic logic [W-1:0] model_word(input logic [3:0] m, input logic [W-1:0] d);
        case (m)
            4'h1: model_word = 11'h400;
            4'h2: model_word = 11'h7FF;
            4'h3: model_word = 11'h000;
            4'h4: model_word = m_phase ? 11'h2AA : 11'h555;
            4'h7: model_word = m_phase ? 11'h000 : 11'h7FF;
            4'h5: model_word = pn_word(m_pn23, 23, 18);
            4'h6: model_word = pn_word({14'd0, m_pn9}, 9, 5);
            default: model_word = d;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp,
                         input logic ga, input logic ea);
        checks++;
        if (got !== exp || ga !== ea) begin
            bad++;
            $display("FAIL %s: got data=%h active=%b, expected data=%h active=%b",
                     req, got, ga, exp, ea);
        end
    endtask

    // Apply one word of stimulus, advance the model, then check the output.
    task automatic step(input logic [3:0] m, input logic h23, input logic h9,
                        input logic [W-1:0] d, input string req);
        logic [W-1:0] exp;
        logic ea;
        tp_mode = m; pn23_hold = h23; pn9_hold = h9; conv_data = d;
        exp = model_word(m, d);
        ea = (m >= 4'h1 && m <= 4'h7);
        @(posedge clk);
        m_phase = ~m_phase;
        m_pn23 = h23 ? '1 : pn_next(m_pn23, 23, 18);
        m_pn9 = h9 ? '1 : 9'(pn_next({14'd0, m_pn9}, 9, 5));
        @(negedge clk);
        check(req, pat_data, exp, pat_active, ea);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_phase = 1'b0; m_pn23 = '1; m_pn9 = '1;
        check("R10", pat_data, '0, pat_active, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin : main
        logic [W-1:0] held;
        @(negedge clk);
        do_reset();
        // R1 R2 R3 R4 R5 R6 R8 R9: table walk
        for (int i = 0; i < NROWS; i++)
            step(ROWS[i].mode, ROWS[i].h23, ROWS[i].h9, ROWS[i].data, "R1-table R2 R3 R4 R5 R6 R8 R9");
        // R5 long run of PN9 and R6 long run of PN23
        for (int i = 0; i < 60; i++) step(4'h6, 1'b0, 1'b0, 11'h0, "R5");
        for (int i = 0; i < 60; i++) step(4'h5, 1'b0, 1'b0, 11'h0, "R6");
        // R7: hold PN9; output repeats the seed word, PN23 keeps running
        for (int i = 0; i < 4; i++) step(4'h6, 1'b0, 1'b1, 11'h0, "R7");
        held = pat_data;
        step(4'h6, 1'b0, 1'b1, 11'h0, "R7");
        check("R7", pat_data, held, pat_active, 1'b1);
        for (int i = 0; i < 5; i++) step(4'h5, 1'b0, 1'b1, 11'h0, "R7");
        for (int i = 0; i < 5; i++) step(4'h5, 1'b1, 1'b0, 11'h0, "R7");
        for (int i = 0; i < 5; i++) step(4'h6, 1'b1, 1'b0, 11'h0, "R7");
        // R8: every unused code passes data
        for (int c = 8; c < 16; c++) step(4'(c), 1'b0, 1'b0, 11'(c * 37), "R8");
        // R3: checkerboard over odd and even phases after a mode change
        for (int i = 0; i < 5; i++) step(4'h4, 1'b0, 1'b0, 11'h0, "R3");
        // R10: reset in mid run restarts phase and generators
        step(4'h6, 1'b0, 1'b0, 11'h0, "R5");
        @(negedge clk);
        do_reset();
        step(4'h4, 1'b0, 1'b0, 11'h0, "R10");
        step(4'h6, 1'b0, 1'b0, 11'h0, "R10");
        step(4'h5, 1'b0, 1'b0, 11'h0, "R10");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule